// File: doc/BRIEF.md
# Transactional Conflict Tracker

This block is the per-thread transaction engine of a core that runs code optimistically. A transaction is opened with a start command that also carries a fallback program address. While it runs, every local load records its cache line in a read set. Every local store records its line in a write set and parks its data in a private speculative buffer, so nothing leaves the block before the transaction finishes. The thread's own loads still see the data it has stored.

Remote coherence requests, each either a read or a write of a line address, are compared with both sets. Sharing a line for reading is allowed. Any overlap where at least one side writes is a conflict and kills the transaction. The transaction also dies when a set runs out of room, when the thread requests an abort, or when nested starts exceed the depth counter. A killed transaction throws away all of its speculative state and sends a redirect to the fallback address. The abort cause is held until the next start. An outermost end without an abort commits the transaction. The buffered stores are then handed to the memory side one per cycle, in the order their lines were first written. New starts are refused until that hand-over is complete.

Top module: `tx_conflict_tracker`

## Requirements
- R1: After reset no transaction is open, commit_o, abort_o, redirect_valid_o, wr_valid_o and ld_hit_o are 0, and abort_cause_o is 4'b0000.
- R2: A start while idle opens a transaction at the next clock edge (in_tx_o rises), records the fallback address and clears abort_cause_o. A start during the hand-over of committed stores is ignored. An end or abort request while no transaction is open has no effect.
- R3: A line is address bits [31:6]. Inside a transaction, a remote write to a line in the read set or the write set aborts the transaction, and so does a remote read of a line in the write set. The cause is bit 0 (4'b0001). A remote read of a line that is only in the read set has no effect. Remote requests are compared with the sets as they stood before that clock edge.
- R4: Any remote request that arrives in the same cycle as the outermost end aborts with cause bit 0, whatever its line.
- R5: An outermost end with no abort condition raises commit_o for one cycle after the edge. In that same cycle the write set starts to drain on wr_valid_o/wr_addr_o/wr_data_o, one line per cycle, in order of first store, with wr_addr_o low 6 bits zero. commit_o and abort_o are never high together.
- R6: An explicit abort request inside a transaction aborts it with cause bit 2 (4'b0100).
- R7: Each set holds 8 distinct lines. A load or store that would allocate a ninth line aborts with cause bit 1 (4'b0010). Accessing a line that is already tracked allocates nothing.
- R8: A start inside a transaction raises the nesting depth, and an inner end lowers it without committing. A start at depth 3 aborts with cause bit 3 (4'b1000).
- R9: On abort, abort_o and redirect_valid_o pulse for one cycle with redirect_pc_o equal to the outermost start's fallback address. Cause bits that fire in the same cycle are ORed into abort_cause_o, which holds until the next accepted start. No buffered store is ever drained from an aborted transaction.
- R10: Inside a transaction, a load whose line is in the write set raises ld_hit_o in the same cycle, and ld_data_o carries the latest data stored to that line. Outside a transaction ld_hit_o is 0.
- R11: Loads and stores issued while no transaction is open are not tracked and leave no buffered data behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_begin_i | input | 1 | Start or nest a transaction |
| fallback_pc_i | input | 32 | Fallback address taken with an outermost start |
| tx_end_i | input | 1 | End the current nesting level |
| tx_abort_i | input | 1 | Explicit abort request |
| ld_req_i | input | 1 | Local load |
| ld_addr_i | input | 32 | Local load byte address |
| ld_hit_o | output | 1 | Load line found in the speculative buffer |
| ld_data_o | output | 32 | Buffered data for the load line |
| st_req_i | input | 1 | Local store |
| st_addr_i | input | 32 | Local store byte address |
| st_data_i | input | 32 | Local store data |
| snp_valid_i | input | 1 | Remote coherence request present |
| snp_write_i | input | 1 | Remote request is a write (1) or a read (0) |
| snp_addr_i | input | 32 | Remote request byte address |
| commit_o | output | 1 | Transaction committed (one-cycle pulse) |
| abort_o | output | 1 | Transaction aborted (one-cycle pulse) |
| redirect_valid_o | output | 1 | Redirect to the fallback address |
| redirect_pc_o | output | 32 | Fallback address |
| abort_cause_o | output | 4 | Latched cause: bit0 conflict, bit1 capacity, bit2 explicit, bit3 nesting |
| in_tx_o | output | 1 | Transaction open |
| wr_valid_o | output | 1 | Committed line being handed to memory |
| wr_addr_o | output | 32 | Committed line address |
| wr_data_o | output | 32 | Committed line data |

## Verification
Every decision is made at the clock edge that samples the request: in_tx_o, commit_o, abort_o, redirect and the latched cause change at that edge and are valid for the following cycle. The first drained line appears in the same cycle as commit_o. ld_hit_o and ld_data_o are combinational, so they respond in the same cycle as the load request. The bench applies stimulus at the falling edge and advances a queue-based model at the rising edge. Both the model comparison and the directed checks with literal values sample at the next falling edge, while the load inputs are still applied, so the comparison happens exactly one edge after each stimulus.

// File: rtl/tx_conflict_tracker.sv
module tx_conflict_tracker #(
  parameter int ADDR_W    = 32,
  parameter int OFS_W     = 6,
  parameter int DATA_W    = 32,
  parameter int PC_W      = 32,
  parameter int SET_DEPTH = 8,
  parameter int NEST_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_begin_i,
  input  logic [PC_W-1:0]   fallback_pc_i,
  input  logic              tx_end_i,
  input  logic              tx_abort_i,
  input  logic              ld_req_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  output logic              ld_hit_o,
  output logic [DATA_W-1:0] ld_data_o,
  input  logic              st_req_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [DATA_W-1:0] st_data_i,
  input  logic              snp_valid_i,
  input  logic              snp_write_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              commit_o,
  output logic              abort_o,
  output logic              redirect_valid_o,
  output logic [PC_W-1:0]   redirect_pc_o,
  output logic [3:0]        abort_cause_o,
  output logic              in_tx_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int LINE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(SET_DEPTH + 1);
  localparam int IDX_W  = (SET_DEPTH > 1) ? $clog2(SET_DEPTH) : 1;
  localparam logic [NEST_W-1:0] MAX_NEST = {NEST_W{1'b1}};
  localparam logic [CNT_W-1:0]  FULL     = CNT_W'(SET_DEPTH);

  typedef enum logic [1:0] {ST_IDLE, ST_TX, ST_DRAIN} state_t;

  state_t            state;
  logic [NEST_W-1:0] depth;
  logic [PC_W-1:0]   fb_pc;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt, drain_idx;
  logic [3:0]        cause_q;
  logic              commit_q, abort_q;
  logic [LINE_W-1:0] rd_tag [SET_DEPTH];
  logic [LINE_W-1:0] wr_tag [SET_DEPTH];
  logic [DATA_W-1:0] wr_data [SET_DEPTH];

  logic [LINE_W-1:0] ld_line, st_line, snp_line;
  assign ld_line  = ld_addr_i[ADDR_W-1:OFS_W];
  assign st_line  = st_addr_i[ADDR_W-1:OFS_W];
  assign snp_line = snp_addr_i[ADDR_W-1:OFS_W];

  logic unused_ofs;
  assign unused_ofs = ^{ld_addr_i[OFS_W-1:0], st_addr_i[OFS_W-1:0], snp_addr_i[OFS_W-1:0]};

  logic [SET_DEPTH-1:0] rd_snp_m, wr_snp_m, rd_ld_m, wr_ld_m, wr_st_m;

  for (genvar g = 0; g < SET_DEPTH; g++) begin : g_cmp
    logic rd_v, wr_v;
    assign rd_v        = CNT_W'(g) < rd_cnt;
    assign wr_v        = CNT_W'(g) < wr_cnt;
    assign rd_snp_m[g] = rd_v && (rd_tag[g] == snp_line);
    assign rd_ld_m[g]  = rd_v && (rd_tag[g] == ld_line);
    assign wr_snp_m[g] = wr_v && (wr_tag[g] == snp_line);
    assign wr_ld_m[g]  = wr_v && (wr_tag[g] == ld_line);
    assign wr_st_m[g]  = wr_v && (wr_tag[g] == st_line);
  end

  logic              in_tx, ld_rd_hit, st_hit;
  logic [IDX_W-1:0]  st_idx;
  logic [DATA_W-1:0] ld_sel;

  assign in_tx     = (state == ST_TX);
  assign ld_rd_hit = |rd_ld_m;
  assign st_hit    = |wr_st_m;

  always_comb begin
    st_idx = '0;
    ld_sel = '0;
    for (int i = 0; i < SET_DEPTH; i++) begin
      if (wr_st_m[i]) st_idx = IDX_W'(i);
      if (wr_ld_m[i]) ld_sel = wr_data[i];
    end
  end

  logic outer_end, conflict, cap, nest_ovf, abort_now, commit_now, tx_go;
  logic [3:0] causes;

  assign outer_end = tx_end_i && (depth == NEST_W'(1));
  assign conflict  = snp_valid_i && ((snp_write_i && (|rd_snp_m || |wr_snp_m)) ||
                                     (!snp_write_i && |wr_snp_m) || outer_end);
  assign cap       = (ld_req_i && !ld_rd_hit && rd_cnt == FULL) ||
                     (st_req_i && !st_hit && wr_cnt == FULL);
  assign nest_ovf  = tx_begin_i && (depth == MAX_NEST);
  assign causes    = in_tx ? {nest_ovf, tx_abort_i, cap, conflict} : 4'b0000;
  assign abort_now = |causes;
  assign commit_now = in_tx && outer_end && !abort_now;
  assign tx_go     = in_tx && !abort_now && !commit_now;

  logic ld_alloc, st_write, st_alloc;
  assign ld_alloc = tx_go && ld_req_i && !ld_rd_hit;
  assign st_write = tx_go && st_req_i;
  assign st_alloc = st_write && !st_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      depth     <= '0;
      fb_pc     <= '0;
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      drain_idx <= '0;
      cause_q   <= '0;
      commit_q  <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      abort_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (tx_begin_i) begin
            state   <= ST_TX;
            depth   <= NEST_W'(1);
            fb_pc   <= fallback_pc_i;
            cause_q <= '0;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
          end
        end
        ST_TX: begin
          if (abort_now) begin
            state   <= ST_IDLE;
            depth   <= '0;
            abort_q <= 1'b1;
            cause_q <= causes;
            rd_cnt  <= '0;
            wr_cnt  <= '0;
          end else if (commit_now) begin
            commit_q  <= 1'b1;
            depth     <= '0;
            rd_cnt    <= '0;
            drain_idx <= '0;
            state     <= (wr_cnt == '0) ? ST_IDLE : ST_DRAIN;
          end else begin
            depth <= depth + NEST_W'(tx_begin_i) - NEST_W'(tx_end_i);
            if (ld_alloc) rd_cnt <= rd_cnt + CNT_W'(1);
            if (st_alloc) wr_cnt <= wr_cnt + CNT_W'(1);
          end
        end
        ST_DRAIN: begin
          if (drain_idx == wr_cnt - CNT_W'(1)) begin
            state  <= ST_IDLE;
            wr_cnt <= '0;
          end
          drain_idx <= drain_idx + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (ld_alloc) rd_tag[rd_cnt[IDX_W-1:0]] <= ld_line;
    if (st_alloc) wr_tag[wr_cnt[IDX_W-1:0]] <= st_line;
    if (st_write) wr_data[st_hit ? st_idx : wr_cnt[IDX_W-1:0]] <= st_data_i;
  end

  assign ld_hit_o         = in_tx && ld_req_i && |wr_ld_m;
  assign ld_data_o        = ld_sel;
  assign commit_o         = commit_q;
  assign abort_o          = abort_q;
  assign redirect_valid_o = abort_q;
  assign redirect_pc_o    = fb_pc;
  assign abort_cause_o    = cause_q;
  assign in_tx_o          = in_tx;
  assign wr_valid_o       = (state == ST_DRAIN);
  assign wr_addr_o        = {wr_tag[drain_idx[IDX_W-1:0]], {OFS_W{1'b0}}};
  assign wr_data_o        = wr_data[drain_idx[IDX_W-1:0]];
endmodule

// File: rtl/tx_conflict_tracker_chk.sv
module tx_conflict_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tx_end_i,
  input logic       commit_o,
  input logic       abort_o,
  input logic [3:0] abort_cause_o,
  input logic       in_tx_o,
  input logic       wr_valid_o,
  input logic       ld_hit_o
);
  // R5
  commit_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(tx_end_i));

  // R5
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_o && abort_o));

  // R9
  abort_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (abort_cause_o != 4'b0000));

  // R9
  abort_closes_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> !in_tx_o);

  // R2
  start_clears_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_tx_o) |-> (abort_cause_o == 4'b0000));

  // R5
  drain_outside_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> !in_tx_o);

  // R10
  forward_in_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hit_o |-> in_tx_o);
endmodule

bind tx_conflict_tracker tx_conflict_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_end_i(tx_end_i), .commit_o(commit_o),
  .abort_o(abort_o), .abort_cause_o(abort_cause_o), .in_tx_o(in_tx_o),
  .wr_valid_o(wr_valid_o), .ld_hit_o(ld_hit_o)
);

// File: tb/sim_tx_conflict_tracker.sv
module sim_tx_conflict_tracker;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic        tx_begin_i, tx_end_i, tx_abort_i;
  logic [31:0] fallback_pc_i;
  logic        ld_req_i, st_req_i, snp_valid_i, snp_write_i;
  logic [31:0] ld_addr_i, st_addr_i, st_data_i, snp_addr_i;
  logic        ld_hit_o, commit_o, abort_o, redirect_valid_o, in_tx_o, wr_valid_o;
  logic [31:0] ld_data_o, redirect_pc_o, wr_addr_o, wr_data_o;
  logic [3:0]  abort_cause_o;

  tx_conflict_tracker u0 (
    .clk(clk), .rst_n(rst_n), .tx_begin_i(tx_begin_i), .fallback_pc_i(fallback_pc_i),
    .tx_end_i(tx_end_i), .tx_abort_i(tx_abort_i), .ld_req_i(ld_req_i), .ld_addr_i(ld_addr_i),
    .ld_hit_o(ld_hit_o), .ld_data_o(ld_data_o), .st_req_i(st_req_i), .st_addr_i(st_addr_i),
    .st_data_i(st_data_i), .snp_valid_i(snp_valid_i), .snp_write_i(snp_write_i),
    .snp_addr_i(snp_addr_i), .commit_o(commit_o), .abort_o(abort_o),
    .redirect_valid_o(redirect_valid_o), .redirect_pc_o(redirect_pc_o),
    .abort_cause_o(abort_cause_o), .in_tx_o(in_tx_o), .wr_valid_o(wr_valid_o),
    .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: 0 idle, 1 open, 2 handing over committed stores
  int          ms, mdepth;
  logic [31:0] mfb;
  logic [3:0]  mcause;
  bit          mcommit, mabort;
  logic [25:0] mrd[$];
  logic [25:0] mwl[$];
  logic [31:0] mwd[$];

  task model_step();
    bit hr, hw, ldr;
    int sidx;
    logic [3:0] c;
    hr = 0; hw = 0; ldr = 0; sidx = -1;
    mcommit = 0; mabort = 0;
    case (ms)
      0: if (tx_begin_i) begin
        ms = 1; mdepth = 1; mfb = fallback_pc_i; mcause = 0;
        mrd.delete(); mwl.delete(); mwd.delete();
      end
      1: begin
        foreach (mrd[i]) begin
          if (mrd[i] == snp_addr_i[31:6]) hr = 1;
          if (mrd[i] == ld_addr_i[31:6]) ldr = 1;
        end
        foreach (mwl[i]) begin
          if (mwl[i] == snp_addr_i[31:6]) hw = 1;
          if (mwl[i] == st_addr_i[31:6]) sidx = i;
        end
        c[0] = snp_valid_i && ((snp_write_i && (hr || hw)) || (!snp_write_i && hw) ||
                               (tx_end_i && mdepth == 1));
        c[1] = (ld_req_i && !ldr && mrd.size() == 8) || (st_req_i && sidx < 0 && mwl.size() == 8);
        c[2] = tx_abort_i;
        c[3] = tx_begin_i && mdepth == 3;
        if (c != 0) begin
          ms = 0; mabort = 1; mcause = c;
          mrd.delete(); mwl.delete(); mwd.delete();
        end else if (tx_end_i && mdepth == 1) begin
          mcommit = 1; mrd.delete();
          ms = (mwl.size() != 0) ? 2 : 0;
        end else begin
          mdepth = mdepth + int'(tx_begin_i) - int'(tx_end_i);
          if (ld_req_i && !ldr) mrd.push_back(ld_addr_i[31:6]);
          if (st_req_i) begin
            if (sidx >= 0) mwd[sidx] = st_data_i;
            else begin mwl.push_back(st_addr_i[31:6]); mwd.push_back(st_data_i); end
          end
        end
      end
      default: begin
        void'(mwl.pop_front()); void'(mwd.pop_front());
        if (mwl.size() == 0) ms = 0;
      end
    endcase
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; mdepth = 0; mfb = 0; mcause = 0; mcommit = 0; mabort = 0;
      mrd.delete(); mwl.delete(); mwd.delete();
    end else model_step();
  end

  task automatic cmp_all();
    bit eh;
    logic [31:0] ed;
    eh = 0; ed = 0;
    if (ms == 1 && ld_req_i)
      foreach (mwl[i]) if (mwl[i] == ld_addr_i[31:6]) begin eh = 1; ed = mwd[i]; end
    chk("R5 commit_o", commit_o, mcommit);
    chk("R9 abort_o", abort_o, mabort);
    chk("R9 redirect_valid_o", redirect_valid_o, mabort);
    if (mabort) chk("R9 redirect_pc_o", redirect_pc_o, mfb);
    chk("R9 abort_cause_o", abort_cause_o, mcause);
    chk("R2 in_tx_o", in_tx_o, ms == 1);
    chk("R5 wr_valid_o", wr_valid_o, ms == 2);
    if (ms == 2) begin
      chk("R5 wr_addr_o", wr_addr_o, {mwl[0], 6'b0});
      chk("R5 wr_data_o", wr_data_o, mwd[0]);
    end
    chk("R10 ld_hit_o", ld_hit_o, eh);
    if (eh) chk("R10 ld_data_o", ld_data_o, ed);
  endtask

  task automatic clr();
    tx_begin_i = 0; tx_end_i = 0; tx_abort_i = 0; fallback_pc_i = 0;
    ld_req_i = 0; ld_addr_i = 0; st_req_i = 0; st_addr_i = 0; st_data_i = 0;
    snp_valid_i = 0; snp_write_i = 0; snp_addr_i = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic do_begin(input logic [31:0] fb);
    clr(); tx_begin_i = 1; fallback_pc_i = fb; tick();
  endtask
  task automatic do_end();
    clr(); tx_end_i = 1; tick();
  endtask
  task automatic do_abort();
    clr(); tx_abort_i = 1; tick();
  endtask
  task automatic do_ld(input logic [31:0] a);
    clr(); ld_req_i = 1; ld_addr_i = a; tick();
  endtask
  task automatic do_st(input logic [31:0] a, input logic [31:0] d);
    clr(); st_req_i = 1; st_addr_i = a; st_data_i = d; tick();
  endtask
  task automatic do_snp(input logic w, input logic [31:0] a);
    clr(); snp_valid_i = 1; snp_write_i = w; snp_addr_i = a; tick();
  endtask
  task automatic do_nop(input int n);
    for (int i = 0; i < n; i++) begin clr(); tick(); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; clr();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    chk("R1 reset in_tx_o", in_tx_o, 0);
    chk("R1 reset abort_cause_o", abort_cause_o, 4'b0000);
    chk("R1 reset commit/abort", {commit_o, abort_o, redirect_valid_o, wr_valid_o}, 4'b0000);

    // R2: end/abort while idle have no effect
    do_abort();
    chk("R2 idle abort ignored", abort_o, 0);
    do_end();
    chk("R2 idle end ignored", commit_o, 0);

    // R10 and R5: buffered stores, forwarding, ordered drain
    do_begin(32'h0000_0100);
    chk("R2 start opens", in_tx_o, 1);
    do_st(32'h0000_1004, 32'hAAAA_0001);
    do_st(32'h0000_2008, 32'hBBBB_0002);
    do_st(32'h0000_103C, 32'hAAAA_0003);
    do_ld(32'h0000_1010);
    chk("R10 forward hit", ld_hit_o, 1);
    chk("R10 forward data", ld_data_o, 32'hAAAA_0003);
    do_ld(32'h0000_3000);
    chk("R10 no forward other line", ld_hit_o, 0);
    do_end();
    chk("R5 commit pulse", commit_o, 1);
    chk("R5 first drain addr", wr_addr_o, 32'h0000_1000);
    do_begin(32'h0000_0111);
    chk("R2 start ignored during drain", in_tx_o, 0);
    chk("R5 second drain addr", wr_addr_o, 32'h0000_2000);
    do_nop(2);

    // R3: read sharing allowed, write to read line aborts
    do_begin(32'h0000_0200);
    do_ld(32'h0000_4000);
    do_snp(0, 32'h0000_4010);
    chk("R3 remote read of read line ignored", abort_o, 0);
    do_snp(1, 32'h0000_4020);
    chk("R3 remote write conflict abort", abort_o, 1);
    chk("R3 conflict cause", abort_cause_o, 4'b0001);
    chk("R9 redirect address", redirect_pc_o, 32'h0000_0200);
    do_nop(1);
    chk("R9 cause held", abort_cause_o, 4'b0001);

    // R3: remote read of a written line aborts; stores discarded
    do_begin(32'h0000_0300);
    do_st(32'h0000_5000, 32'h1234_5678);
    do_snp(0, 32'h0000_5004);
    chk("R3 remote read of write line", abort_cause_o, 4'b0001);
    do_nop(1);
    chk("R9 nothing drained after abort", wr_valid_o, 0);

    // R4: remote request with outermost end
    do_begin(32'h0000_0400);
    do_ld(32'h0000_6000);
    clr(); tx_end_i = 1; snp_valid_i = 1; snp_write_i = 0; snp_addr_i = 32'h0000_7700; tick();
    chk("R4 end with remote aborts", abort_o, 1);
    chk("R4 no commit", commit_o, 0);

    // R11 and R6
    do_st(32'h0000_8000, 32'hDEAD_BEEF);
    do_begin(32'h0000_0500);
    chk("R2 cause cleared on start", abort_cause_o, 4'b0000);
    do_ld(32'h0000_8000);
    chk("R11 idle store not buffered", ld_hit_o, 0);
    do_abort();
    chk("R6 explicit abort cause", abort_cause_o, 4'b0100);

    // R7: read set capacity
    do_begin(32'h0000_0600);
    for (int i = 0; i < 8; i++) do_ld(32'h0001_0000 + i * 64);
    do_ld(32'h0001_00C4);
    chk("R7 repeat line no abort", abort_o, 0);
    do_ld(32'h0001_0200);
    chk("R7 read overflow cause", abort_cause_o, 4'b0010);
    // R7: write set capacity
    do_begin(32'h0000_0610);
    for (int i = 0; i < 8; i++) do_st(32'h0002_0000 + i * 64, i);
    do_st(32'h0002_0008, 32'h77);
    chk("R7 repeat store no abort", abort_o, 0);
    do_st(32'h0002_0200, 32'h88);
    chk("R7 write overflow cause", abort_cause_o, 4'b0010);

    // R8: nesting
    do_begin(32'h0000_0700);
    do_begin(32'h0000_0701);
    do_begin(32'h0000_0702);
    do_end();
    do_end();
    chk("R8 inner ends keep tx", in_tx_o, 1);
    do_end();
    chk("R8 outer end commits", commit_o, 1);
    do_begin(32'h0000_0800);
    do_begin(32'h0000_0801);
    do_begin(32'h0000_0802);
    do_begin(32'h0000_0803);
    chk("R8 nest overflow cause", abort_cause_o, 4'b1000);
    chk("R9 redirect outer fallback", redirect_pc_o, 32'h0000_0800);

    // mixed traffic against the model
    for (int k = 0; k < 4000; k++) begin
      clr();
      tx_begin_i    = ($urandom_range(0, 11) == 0);
      fallback_pc_i = $urandom;
      tx_end_i      = ($urandom_range(0, 9) == 0);
      tx_abort_i    = ($urandom_range(0, 79) == 0);
      ld_req_i      = ($urandom_range(0, 2) == 0);
      ld_addr_i     = {20'h0, 6'($urandom_range(0, 11)), 6'($urandom)};
      st_req_i      = ($urandom_range(0, 2) == 0);
      st_addr_i     = {20'h0, 6'($urandom_range(0, 11)), 6'($urandom)};
      st_data_i     = $urandom;
      snp_valid_i   = ($urandom_range(0, 9) == 0);
      snp_write_i   = $urandom_range(0, 1);
      snp_addr_i    = {20'h0, 6'($urandom_range(0, 30)), 6'($urandom)};
      tick();
    end
    do_nop(12);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule